// File: doc/BRIEF.md
# Pulse-Width Serial Bit Decoder

This block turns a single programming wire into a stream of bits and words. Each bit takes one fixed period on the wire. The wire goes high at the start of every bit, and the length of that high phase carries the value: about a fifth of the period means zero, and about four fifths means one. The block synchronizes the wire to a fast system clock. It then waits a programmable number of cycles after each rising edge and takes the wire level at that moment as the bit.

An enable input gates the decoder. After the enable goes high, it must stay high for a programmable number of cycles before any rising edge is decoded. A fixed six-bit entry sequence must arrive before data is accepted. Once it has arrived, the block raises a frame flag. It then shifts data bits into words, most significant bit first, and pulses a strobe for each complete word.

A watchdog covers each high and low phase while a sequence is in progress. If a phase stays unchanged too long, the block flags an error and goes back to hunting for the entry sequence. Dropping the enable returns the block to idle at any time.

Top module: `pwbit_decoder`

## Requirements
- R1: While reset is active or the enable is low, `bit_valid_o`, `word_done_o`, `frame_valid_o` and `timeout_err_o` are all 0.
- R2: The bit value is the synchronized line level SAMPLE_DLY cycles after its rising edge. A high phase shorter than SAMPLE_DLY decodes as 0, and a high phase longer than SAMPLE_DLY decodes as 1.
- R3: Every rising edge that is accepted produces exactly one `bit_valid_o` pulse, carrying the bit on `bit_data_o`.
- R4: A rising edge that comes before the enable has been high for CE_SETUP_CYC cycles produces no bit strobe.
- R5: Data is accepted only after the bits 0,0,1,1,0,0 have arrived in that order, with the first bit received first. `frame_valid_o` rises in the same cycle as the strobe of the sixth bit of that sequence.
- R6: While the frame flag is high, bits shift into a WORD_W-bit word, with the first bit received ending up in the most significant position. `word_done_o` pulses in the same cycle as the strobe of the last bit, with the word on `word_data_o`. Decoding then carries on with the next word.
- R7: A sequence is in progress when at least one entry bit has been received or the frame flag is high. If the line holds one level for TIMEOUT_CYC cycles during a sequence, `timeout_err_o` pulses for one cycle. At the same time the frame flag clears, the partial word and entry history are discarded, and the entry sequence is required again.
- R8: Dropping the enable clears the frame flag and the partial word, and restarts the enable setup count.
- R9: When no sequence is in progress, an idle line of any length raises no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Decoder enable, synchronous to clk |
| sdata_i | input | 1 | Asynchronous programming line |
| bit_valid_o | output | 1 | One-cycle strobe for a decoded bit |
| bit_data_o | output | 1 | Value of the bit that was just decoded |
| word_done_o | output | 1 | One-cycle strobe for a completed word |
| word_data_o | output | WORD_W | Last completed word, first bit in the MSB |
| frame_valid_o | output | 1 | High once the entry sequence has been received |
| timeout_err_o | output | 1 | One-cycle strobe when a phase watchdog expires |

## Verification
Two pairs of events share a cycle. The strobe of the final bit of a word arrives together with the word strobe, and the sixth entry bit arrives together with the rise of the frame flag. Both pairs come up whenever a full entry sequence and full words are sent. The scoreboard expects the items of each pair in a fixed order within one cycle, and a separate check confirms that the frame rise coincides with a bit strobe of value zero. Timeouts are provoked by idling after a partial entry sequence, after a partial word and after a full frame, and must then appear as the only event in the queue.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HUNT, ST_DATA} pwd_state_e;

  // entry sequence, oldest bit in the MSB: 0,0,1,1,0,0
  localparam logic [5:0] ENTRY_SEQ = 6'b001100;

  function automatic logic [5:0] hist_push(logic [5:0] h, logic b);
    return {h[4:0], b};
  endfunction

  function automatic logic [2:0] hist_count(logic [2:0] n);
    return (n == 3'd6) ? 3'd6 : n + 3'd1;
  endfunction

  function automatic logic entry_hit(logic [5:0] h, logic [2:0] n);
    return (n == 3'd6) && (h == ENTRY_SEQ);
  endfunction
endpackage

// File: rtl/pwd_sync.sv
module pwd_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic lvl_o,
  output logic rise_o,
  output logic edge_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= in_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign lvl_o  = s2;
  assign rise_o = s2 & ~s3;
  assign edge_o = s2 ^ s3;
endmodule

// File: rtl/pwd_counters.sv
module pwd_setup #(
  parameter int unsigned SETUP_CYC = 5358
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(SETUP_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (!ce_i)                   cnt <= '0;
    else if (cnt != CW'(SETUP_CYC))   cnt <= cnt + 1'b1;
  end

  assign ready_o = (cnt == CW'(SETUP_CYC));
endmodule

module pwd_phase_timer #(
  parameter int unsigned LIMIT = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic edge_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr_i || edge_i)     cnt <= '0;
    else if (cnt != CW'(LIMIT))   cnt <= cnt + 1'b1;
  end

  assign expire_o = (cnt == CW'(LIMIT - 1)) && !edge_i && !clr_i;
endmodule

module pwd_sampler #(
  parameter int unsigned DLY = 893
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic arm_i,
  output logic take_o
);
  localparam int unsigned CW = $clog2(DLY + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr_i)        cnt <= '0;
    else if (arm_i)        cnt <= CW'(DLY);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign take_o = (cnt == CW'(1));
endmodule

// File: rtl/pwbit_decoder.sv
module pwbit_decoder
  import pwd_pkg::*;
#(
  parameter int unsigned WORD_W       = 8,
  parameter int unsigned SAMPLE_DLY   = 893,
  parameter int unsigned TIMEOUT_CYC  = 2000,
  parameter int unsigned CE_SETUP_CYC = 5358
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              sdata_i,
  output logic              bit_valid_o,
  output logic              bit_data_o,
  output logic              word_done_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic              frame_valid_o,
  output logic              timeout_err_o
);
  localparam int unsigned BCNT_W = $clog2(WORD_W + 1);

  function automatic logic [WORD_W-1:0] word_shift(logic [WORD_W-1:0] w, logic b);
    return {w[WORD_W-2:0], b};
  endfunction

  // internal events, brought out for the checker
  logic line_lvl, line_rise, line_edge;
  logic ce_ready, samp_take, phase_expire, seq_armed;

  pwd_state_e        state;
  logic [5:0]        hist;
  logic [2:0]        hcnt;
  logic [WORD_W-1:0] shreg;
  logic [BCNT_W-1:0] bcnt;

  pwd_sync u_sync (
    .clk(clk), .rst_n(rst_n), .in_i(sdata_i),
    .lvl_o(line_lvl), .rise_o(line_rise), .edge_o(line_edge)
  );

  pwd_setup #(.SETUP_CYC(CE_SETUP_CYC)) u_setup (
    .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .ready_o(ce_ready)
  );

  pwd_sampler #(.DLY(SAMPLE_DLY)) u_samp (
    .clk(clk), .rst_n(rst_n), .clr_i(!ce_i),
    .arm_i(line_rise && ce_ready && ce_i), .take_o(samp_take)
  );

  pwd_phase_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr_i(!ce_i),
    .edge_i(line_edge), .expire_o(phase_expire)
  );

  assign seq_armed     = (state == ST_DATA) || ((state == ST_HUNT) && (hcnt != 3'd0));
  assign frame_valid_o = (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      hist          <= '0;
      hcnt          <= '0;
      shreg         <= '0;
      bcnt          <= '0;
      bit_valid_o   <= 1'b0;
      bit_data_o    <= 1'b0;
      word_done_o   <= 1'b0;
      word_data_o   <= '0;
      timeout_err_o <= 1'b0;
    end else if (!ce_i) begin
      state         <= ST_IDLE;
      hist          <= '0;
      hcnt          <= '0;
      shreg         <= '0;
      bcnt          <= '0;
      bit_valid_o   <= 1'b0;
      word_done_o   <= 1'b0;
      timeout_err_o <= 1'b0;
    end else begin
      bit_valid_o   <= 1'b0;
      word_done_o   <= 1'b0;
      timeout_err_o <= 1'b0;
      if (state == ST_IDLE && ce_ready) state <= ST_HUNT;

      if (phase_expire && seq_armed) begin
        timeout_err_o <= 1'b1;
        state         <= ST_HUNT;
        hist          <= '0;
        hcnt          <= '0;
        shreg         <= '0;
        bcnt          <= '0;
      end else if (samp_take) begin
        bit_valid_o <= 1'b1;
        bit_data_o  <= line_lvl;
        if (state == ST_DATA) begin
          shreg <= word_shift(shreg, line_lvl);
          if (bcnt == BCNT_W'(WORD_W - 1)) begin
            word_done_o <= 1'b1;
            word_data_o <= word_shift(shreg, line_lvl);
            bcnt        <= '0;
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end else begin
          hist <= hist_push(hist, line_lvl);
          hcnt <= hist_count(hcnt);
          if (entry_hit(hist_push(hist, line_lvl), hist_count(hcnt))) begin
            state <= ST_DATA;
            shreg <= '0;
            bcnt  <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwd_chk.sv
module pwd_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_i,
  input logic bit_valid_o,
  input logic bit_data_o,
  input logic word_done_o,
  input logic frame_valid_o,
  input logic timeout_err_o,
  input logic ce_ready,
  input logic samp_take,
  input logic seq_armed
);
  // R8
  ce_drop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |=> (!bit_valid_o && !word_done_o && !frame_valid_o && !timeout_err_o));

  // R4
  early_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid_o |-> ce_ready);

  // R3
  take_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_take && ce_i) |=> bit_valid_o);

  // R5
  frame_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid_o) |-> (bit_valid_o && !bit_data_o));

  // R6
  word_with_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done_o |-> (bit_valid_o && frame_valid_o));

  // R7
  timeout_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err_o |-> (!frame_valid_o && !bit_valid_o));

  // R9
  timeout_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err_o |-> $past(seq_armed));
endmodule

bind pwbit_decoder pwd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_i(ce_i),
  .bit_valid_o(bit_valid_o), .bit_data_o(bit_data_o),
  .word_done_o(word_done_o), .frame_valid_o(frame_valid_o),
  .timeout_err_o(timeout_err_o), .ce_ready(ce_ready),
  .samp_take(samp_take), .seq_armed(seq_armed)
);

// File: tb/sim_pwbit_decoder.sv
module sim_pwbit_decoder;
  localparam int W = 8, DLY = 20, TMO = 60, SETUP = 120;
  localparam int PER = 40, HI0 = 8, HI1 = 32;
  localparam logic [1:0] K_BIT = 2'd0, K_FRAME = 2'd1, K_WORD = 2'd2, K_TMO = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, sdata = 1'b0;
  logic bit_valid, bit_data, word_done, frame_valid, timeout_err;
  logic [W-1:0] word_data;

  always #4 clk = ~clk;

  pwbit_decoder #(.WORD_W(W), .SAMPLE_DLY(DLY), .TIMEOUT_CYC(TMO), .CE_SETUP_CYC(SETUP)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sdata_i(sdata),
    .bit_valid_o(bit_valid), .bit_data_o(bit_data), .word_done_o(word_done),
    .word_data_o(word_data), .frame_valid_o(frame_valid), .timeout_err_o(timeout_err)
  );

  int total = 0, bad = 0, bits_seen = 0, tmo_seen = 0, words_seen = 0;
  logic [9:0] exp_q[$];
  bit done = 1'b0;

  // bench model state
  bit m_live = 1'b0, m_frame = 1'b0;
  logic [5:0] m_hist = '0;
  int m_hcnt = 0, m_bcnt = 0;
  logic [W-1:0] m_word = '0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_frame = 1'b0; m_hist = '0; m_hcnt = 0; m_bcnt = 0; m_word = '0;
  endtask

  task automatic send_bit(bit b);
    if (m_live) begin
      exp_q.push_back({K_BIT, 7'd0, b});
      if (m_frame) begin
        m_word = {m_word[W-2:0], b};
        m_bcnt++;
        if (m_bcnt == W) begin
          exp_q.push_back({K_WORD, m_word});
          m_bcnt = 0;
        end
      end else begin
        m_hist = {m_hist[4:0], b};
        if (m_hcnt < 6) m_hcnt++;
        if (m_hcnt == 6 && m_hist == 6'b001100) begin
          m_frame = 1'b1; m_bcnt = 0;
          exp_q.push_back({K_FRAME, 8'd0});
        end
      end
    end
    @(negedge clk) sdata = 1'b1;
    repeat ((b ? HI1 : HI0) - 1) @(negedge clk);
    @(negedge clk) sdata = 1'b0;
    repeat (PER - (b ? HI1 : HI0) - 1) @(negedge clk);
  endtask

  task automatic send_bits(int n, logic [15:0] v);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_long();
    if (m_frame || m_hcnt != 0) begin
      exp_q.push_back({K_TMO, 8'd0});
      m_reset();
    end
    idle(100);
  endtask

  task automatic expect_item(logic [1:0] k, logic [7:0] d);
    logic [9:0] e;
    string req;
    req = (k == K_BIT) ? "R2" : (k == K_FRAME) ? "R5" : (k == K_WORD) ? "R6" : "R7";
    total++;
    if (exp_q.size() == 0) begin
      bad++;
      $display("FAIL %s unexpected event actual=%0d expected=none", req, {k, d});
    end else begin
      e = exp_q.pop_front();
      if (e != {k, d}) begin
        bad++;
        $display("FAIL %s actual=%0d expected=%0d", req, {k, d}, e);
      end
    end
  endtask

  // monitor
  initial begin
    logic fv_q;
    fv_q = 1'b0;
    forever @(negedge clk) if (rst_n) begin
      if (bit_valid) begin expect_item(K_BIT, {7'd0, bit_data}); bits_seen++; end
      if (frame_valid && !fv_q) begin
        expect_item(K_FRAME, 8'd0);
        chk(bit_valid && !bit_data, "R5 frame rise with sixth bit", int'({bit_valid, bit_data}), 2);
      end
      if (word_done) begin expect_item(K_WORD, word_data); words_seen++; end
      if (timeout_err) begin expect_item(K_TMO, 8'd0); tmo_seen++; end
      fv_q = frame_valid;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int b0, t0, w0;
    idle(5);
    // R1: reset state
    chk(!bit_valid && !word_done && !frame_valid && !timeout_err, "R1 reset outputs",
        int'({bit_valid, word_done, frame_valid, timeout_err}), 0);
    rst_n = 1'b1;
    idle(5);
    chk(!frame_valid && !timeout_err, "R1 enable low", int'({frame_valid, timeout_err}), 0);

    // R4: bits before setup time are ignored
    ce = 1'b1;
    b0 = bits_seen;
    send_bits(2, 16'b11);
    idle(60);
    chk(bits_seen == b0, "R4 early bits", bits_seen - b0, 0);
    m_live = 1'b1;

    // R9: idle with nothing in progress
    t0 = tmo_seen;
    idle(200);
    chk(tmo_seen == t0, "R9 idle no timeout", tmo_seen - t0, 0);

    // R5 R6: false start, entry, two words, then R7 timeout from frame
    send_bits(2, 16'b10);
    send_bits(6, 16'b001100);
    send_bits(8, 16'hA5);
    send_bits(8, 16'h3C);
    chk(frame_valid, "R5 frame flag up", int'(frame_valid), 1);
    idle_long();
    chk(!frame_valid, "R7 frame dropped", int'(frame_valid), 0);

    // R7: partial entry then idle
    send_bits(3, 16'b001);
    idle_long();

    // R7: partial word discarded
    send_bits(6, 16'b001100);
    send_bits(3, 16'b111);
    idle_long();
    send_bits(6, 16'b001100);
    send_bits(8, 16'h5A);
    chk(word_data == 8'h5A, "R6 fresh word after timeout", int'(word_data), 8'h5A);
    idle_long();

    // R8: enable drop mid word
    send_bits(6, 16'b001100);
    send_bits(3, 16'b101);
    w0 = words_seen;
    @(negedge clk) ce = 1'b0;
    m_reset(); m_live = 1'b0;
    idle(10);
    chk(!frame_valid, "R8 frame cleared", int'(frame_valid), 0);
    ce = 1'b1;
    idle(140);
    m_live = 1'b1;
    send_bits(6, 16'b001100);
    send_bits(8, 16'hF0);
    chk(words_seen == w0 + 1 && word_data == 8'hF0, "R8 partial word dropped", int'(word_data), 8'hF0);
    idle_long();

    idle(50);
    // R3: every accepted edge produced exactly its expected strobes
    chk(exp_q.size() == 0, "R3 pending items", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule